// File: doc/BRIEF.md
# Virtqueue Doorbell Address Decoder

This block watches the write path of one memory window and picks out queue-notify ("doorbell") writes. Every virtqueue carries a notify slot number; the byte address of its doorbell is the notification area base plus that slot number times a per-device stride. The stride is either zero, which folds every queue onto the base address, or a power of two no smaller than 2. Any other stride value makes the whole notification area inert.

A doorbell write is a 2-byte store whose data is the index of the virtqueue being notified. When a write lands on a doorbell with exactly the two byte lanes of that halfword enabled, the block emits a one-clock notify pulse carrying the 16-bit index. An index outside the configured queue count gives a one-clock error pulse instead. Queue processing and interrupt delivery sit downstream.

Top module: `qn_doorbell_decode`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, ntf_valid_o, ntf_err_o and ntf_qidx_o are 0.
- R2: For a stride of 2^k with k at least 1, the doorbell byte address of queue q is (base_off_i + q_off[q] * stride) mod 2^ADDR_W, where q_off[q] is q_off_i[q*OFF_W +: OFF_W].
- R3: A stride of 0 places every queue's doorbell at base_off_i.
- R4: A stride of 1, or any nonzero value that is not a power of two, disables the decoder: no notify and no error pulse follow any write.
- R5: A write hits doorbell byte address D only when wr_dw_addr_i equals D[ADDR_W-1:2] and wr_be_i is exactly 4'b0011 if D[1] is 0, or exactly 4'b1100 if D[1] is 1; any other byte-enable pattern is dropped.
- R6: The notified index is wr_data_i[15:0] for a hit on the low halfword and wr_data_i[31:16] for a hit on the high halfword.
- R7: A hit whose index is NUM_Q or larger raises ntf_err_o instead of ntf_valid_o; ntf_qidx_o still shows the index.
- R8: Outputs are registered: a hit in the cycle where wr_valid_i is high gives a pulse in the next cycle only, one pulse per accepted write, and nothing follows when wr_valid_i is low.
- R9: Writes to addresses that are not a doorbell give no pulse of either kind.
- R10: A doorbell address with bit 0 set (odd base) never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write strobe, one write per high cycle |
| wr_dw_addr_i | input | ADDR_W-2 | Dword address of the write within the window |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables, bit n for byte lane n |
| base_off_i | input | ADDR_W | Byte offset of the notification area |
| mult_i | input | 32 | Doorbell stride in bytes |
| q_off_i | input | NUM_Q*OFF_W | Per-queue notify slot numbers, queue 0 in the low bits |
| ntf_valid_o | output | 1 | Notify pulse |
| ntf_err_o | output | 1 | Out-of-range index pulse |
| ntf_qidx_o | output | 16 | Index of the last hit |

## Verification
Both pulses and the index are due exactly one clock after the edge that samples the write, and are gone one clock later. The bench drives each write on a falling edge, holds it across one rising edge, checks the outputs on the next falling edge, then checks on the following falling edge that the pulse has ended. Expected hits come from an arithmetic model that multiplies the slot number by the stride, swept over several strides, bases, offset tables, a halfword address window and all byte-enable patterns.

// File: rtl/qn_pkg.sv
package qn_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned IDX_W  = 16;
  localparam logic [BE_W-1:0] BE_LO_HALF = 4'b0011;
  localparam logic [BE_W-1:0] BE_HI_HALF = 4'b1100;
endpackage

// File: rtl/qn_mult_decode.sv
module qn_mult_decode #(
  parameter int unsigned MULT_W = 32,
  localparam int unsigned SH_W  = $clog2(MULT_W)
) (
  input  logic [MULT_W-1:0] mult_i,
  output logic [SH_W-1:0]   shift_o,
  output logic              zero_o,
  output logic              ok_o
);
  always_comb begin
    shift_o = '0;
    for (int i = 0; i < MULT_W; i++) begin
      if (mult_i[i]) shift_o = SH_W'(i);
    end
  end

  assign zero_o = (mult_i == '0);
  // stride must be 0 or a power of two >= 2
  assign ok_o   = zero_o | ($onehot(mult_i) & ~mult_i[0]);
endmodule

// File: rtl/qn_slot_match.sv
module qn_slot_match
  import qn_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned SH_W   = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic              zero_i,
  input  logic [ADDR_W-3:0] wr_dw_addr_i,
  input  logic [BE_W-1:0]   wr_be_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] db_addr;
  logic [BE_W-1:0]   lane_be;

  assign scaled  = ADDR_W'(off_i) << shift_i;
  assign db_addr = base_i + (zero_i ? '0 : scaled);
  assign lane_be = db_addr[1] ? BE_HI_HALF : BE_LO_HALF;
  assign hit_o   = ~db_addr[0]
                 & (db_addr[ADDR_W-1:2] == wr_dw_addr_i)
                 & (wr_be_i == lane_be);
endmodule

// File: rtl/qn_doorbell_decode.sv
module qn_doorbell_decode
  import qn_pkg::*;
#(
  parameter int unsigned NUM_Q  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned MULT_W = 32,
  localparam int unsigned SH_W  = $clog2(MULT_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-3:0]      wr_dw_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [BE_W-1:0]        wr_be_i,
  input  logic [ADDR_W-1:0]      base_off_i,
  input  logic [MULT_W-1:0]      mult_i,
  input  logic [NUM_Q*OFF_W-1:0] q_off_i,
  output logic                   ntf_valid_o,
  output logic                   ntf_err_o,
  output logic [IDX_W-1:0]       ntf_qidx_o
);
  logic [SH_W-1:0]  shift;
  logic             mult_zero, mult_ok;
  logic [NUM_Q-1:0] slot_hit;
  logic             accept;
  logic [IDX_W-1:0] wr_idx;
  logic             idx_in_range;

  qn_mult_decode #(.MULT_W(MULT_W)) u_mult (
    .mult_i (mult_i),
    .shift_o(shift),
    .zero_o (mult_zero),
    .ok_o   (mult_ok)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
    qn_slot_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SH_W(SH_W)) u_slot (
      .base_i      (base_off_i),
      .off_i       (q_off_i[q*OFF_W +: OFF_W]),
      .shift_i     (shift),
      .zero_i      (mult_zero),
      .wr_dw_addr_i(wr_dw_addr_i),
      .wr_be_i     (wr_be_i),
      .hit_o       (slot_hit[q])
    );
  end

  assign accept       = wr_valid_i & mult_ok & (|slot_hit);
  assign wr_idx       = (wr_be_i == BE_HI_HALF) ? wr_data_i[31:16] : wr_data_i[15:0];
  assign idx_in_range = (32'(wr_idx) < NUM_Q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ntf_valid_o <= 1'b0;
      ntf_err_o   <= 1'b0;
      ntf_qidx_o  <= '0;
    end else begin
      ntf_valid_o <= accept & idx_in_range;
      ntf_err_o   <= accept & ~idx_in_range;
      if (accept) ntf_qidx_o <= wr_idx;
    end
  end

  // R8: a pulse only follows a write cycle
  a_r8_pulse_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_valid_o || ntf_err_o) |-> $past(wr_valid_i));

  // R4: invalid stride never yields a pulse
  a_r4_bad_stride_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_valid_o || ntf_err_o) |-> ($past(mult_i) != 32'd1));

  // R5: accepted writes are exactly one halfword wide
  a_r5_halfword_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_valid_o || ntf_err_o) |->
      ($past(wr_be_i) == BE_LO_HALF || $past(wr_be_i) == BE_HI_HALF));

  // R7: valid pulses carry in-range indices
  a_r7_valid_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> (32'(ntf_qidx_o) < NUM_Q));

  // R6: index follows the written lane
  a_r6_lane_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> (ntf_qidx_o == ($past(wr_be_i) == BE_HI_HALF ?
                                    $past(wr_data_i[31:16]) : $past(wr_data_i[15:0]))));

  // R7: at most one of the two pulses
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ntf_valid_o, ntf_err_o}));
endmodule

// File: tb/tb_qn_doorbell_decode.sv
`timescale 1ns/1ps
module tb_qn_doorbell_decode;
  localparam int NQ = 4;
  localparam int AW = 16;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-3:0] wr_dw_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic [AW-1:0] base_off = '0;
  logic [31:0]   mult = '0;
  logic [NQ*OW-1:0] q_off = '0;
  logic          ntf_valid, ntf_err;
  logic [15:0]   ntf_qidx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  qn_doorbell_decode #(.NUM_Q(NQ), .ADDR_W(AW), .OFF_W(OW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_dw_addr_i(wr_dw_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .base_off_i(base_off), .mult_i(mult),
    .q_off_i(q_off), .ntf_valid_o(ntf_valid), .ntf_err_o(ntf_err), .ntf_qidx_o(ntf_qidx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit stride_ok();
    return (mult == 0) || (mult >= 2 && (mult & (mult - 1)) == 0);
  endfunction

  function automatic logic [15:0] db_addr(input int q);
    logic [31:0] off;
    off = 32'(q_off[q*OW +: OW]);
    if (mult == 0) return base_off;
    return 16'(32'(base_off) + off * mult);
  endfunction

  function automatic string tag_cfg();
    if (!stride_ok()) return "R4";
    if (mult == 0) return "R3";
    return "R2";
  endfunction

  // one write; expected outcome from the arithmetic model
  task automatic do_write(input logic [15:0] baddr, input logic [31:0] data,
                          input logic [3:0] be, input string tag);
    bit hit = 1'b0;
    logic [15:0] idx;
    for (int q = 0; q < NQ; q++) begin
      logic [15:0] d;
      d = db_addr(q);
      if (stride_ok() && !d[0] && d[15:2] == baddr[15:2] &&
          be == (d[1] ? 4'b1100 : 4'b0011)) hit = 1'b1;
    end
    idx = (be == 4'b1100) ? data[31:16] : data[15:0];
    @(negedge clk);
    wr_valid = 1'b1; wr_dw_addr = baddr[15:2]; wr_data = data; wr_be = be;
    @(negedge clk);
    wr_valid = 1'b0;
    check({tag, " valid"}, 32'(ntf_valid), 32'(hit && idx < NQ));
    check({tag, " R7 err"}, 32'(ntf_err), 32'(hit && idx >= NQ));
    if (hit) check({tag, " R6 idx"}, 32'(ntf_qidx), 32'(idx));
    @(negedge clk);
    check("R8 pulse ends valid", 32'(ntf_valid), 0);
    check("R8 pulse ends err", 32'(ntf_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] mults [7] = '{0, 2, 4, 16, 1, 6, 3};
    logic [15:0] bases [3] = '{16'h0100, 16'h0202, 16'h0301};
    logic [31:0] offs  [2] = '{32'h05020100, 32'h01000303};

    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(ntf_valid), 0);
    check("R1 reset err", 32'(ntf_err), 0);
    check("R1 reset idx", 32'(ntf_qidx), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset valid", 32'(ntf_valid), 0);

    foreach (mults[m]) foreach (bases[b]) foreach (offs[o]) begin
      mult = mults[m]; base_off = bases[b]; q_off = offs[o];
      // each queue's own doorbell, index in its own lane
      for (int q = 0; q < NQ; q++) begin
        logic [15:0] d;
        d = db_addr(q);
        if (d[1]) do_write(d, {16'(q), 16'hAAAA}, 4'b1100, d[0] ? "R10" : tag_cfg());
        else      do_write(d, {16'h5555, 16'(q)}, 4'b0011, d[0] ? "R10" : tag_cfg());
      end
      // out-of-range indices on queue 0's doorbell
      begin
        logic [15:0] d;
        d = db_addr(0);
        do_write(d, {16'd4, 16'd4}, d[1] ? 4'b1100 : 4'b0011, "R7");
        do_write(d, 32'hFFFF_FFFF, d[1] ? 4'b1100 : 4'b0011, "R7");
        do_write(d, {16'd2, 16'd1}, 4'b1111, "R5");
      end
      // halfword address window sweep around the area
      for (int a = -8; a < 56; a += 2) begin
        logic [15:0] ba;
        ba = 16'(32'(base_off) + a) & 16'hFFFE;
        do_write(ba, {16'(a & 3), 16'((a >> 1) % 6)}, ba[1] ? 4'b1100 : 4'b0011, "R9");
      end
    end

    // all byte-enable patterns on one doorbell
    mult = 4; base_off = 16'h0100; q_off = 32'h05020100;
    for (int be = 0; be < 16; be++) begin
      logic [15:0] d;
      d = db_addr(1);
      do_write(d, {16'd1, 16'd1}, 4'(be), "R5");
    end
    // idle bus: no pulse
    @(negedge clk);
    wr_dw_addr = db_addr(0) >> 2; wr_be = 4'b0011; wr_data = 0;
    @(negedge clk);
    check("R8 idle valid", 32'(ntf_valid), 0);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule